// File: doc/BRIEF.md
# Byte-Register Target on a Two-Wire Serial Bus

This block is the bus-facing half of a small sensor-style peripheral. It watches a two-wire serial bus (clock and data, both open-drain), recognises its own 7-bit device address, and gives the bus controller read and write access to fifteen byte-wide registers. The bus lines are sampled on a fast system clock, so the block finds START and STOP conditions and clock edges by comparing consecutive synchronised samples. It answers by pulling the data line low through an output-enable pin.

A transfer sets an internal register pointer first. It then writes one or more bytes, or it re-addresses the device with a repeated START and reads one or more bytes. The pointer steps forward after each byte and wraps past the last register. Register 0 behaves specially: it always reads back a fixed identifier, and one key value written to it returns every register to its power-up value. Register 8 is a read-only status byte, and the block emits a pulse each time a byte of it has been shifted onto the bus. Every accepted write byte also shows up on a one-cycle strobe with its address and data, so that neighbouring logic can react to it.

Top module: `i2c_reg_target`

## Requirements
- R1: The device address is 1000100b in the upper seven bits of the first byte after START, sent MSB first, with bit 0 selecting read (1) or write (0). A byte with any other address gets no ACK, and the block ignores the bus until the next START.
- R2: The block ACKs a matching address byte, the register-address byte and every written data byte by asserting `sda_oe` (SDA pulled low) for the ninth clock.
- R3: A read uses a write phase that sets the pointer, then a repeated START with the read bit. Data leave MSB first. A controller ACK fetches the next byte, and a NACK ends the read. SDA changes only while SCL is low.
- R4: Reading register 0x00 returns 0x7D. Writing any value other than 0x46 to it changes nothing.
- R5: Writing 0x46 to register 0x00 puts every register back to its default value.
- R6: The pointer advances by one after each byte and wraps from 0x0E to 0x00. A register-address byte of 0x0F or above sets the pointer to 0x00.
- R7: A STOP that arrives before the ACK clock of a data byte has ended cancels that byte. No register changes and no write strobe fires.
- R8: Default values are 0x00 for registers 0x01 to 0x05, 0xFF for 0x06 and 0x07, 0x04 for 0x08, and 0x00 for 0x09 to 0x0E.
- R9: Register 0x08 is read-only. A write to it is ACKed but leaves its value at 0x04.
- R10: Each accepted data byte raises `rf_wr_stb` for exactly one clock, with `rf_wr_addr` set to the register written and `rf_wr_data` set to the byte.
- R11: `stat_rd_pulse` is high for exactly one clock once the eighth bit of a byte read from register 0x08 has been sent. It stays low for reads of other registers.
- R12: During reset and while the bus is idle, `sda_oe` is low and both strobes are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as sampled from the pad |
| sda_i | input | 1 | Bus data line as sampled from the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rf_wr_stb | output | 1 | One-cycle pulse per accepted write byte |
| rf_wr_addr | output | 4 | Register index of the accepted write |
| rf_wr_data | output | 8 | Byte of the accepted write |
| stat_rd_pulse | output | 1 | One-cycle pulse after a status byte has been sent |

## Verification
The checker watches every clock and confirms three things. Both strobes last a single cycle. `sda_oe` only rises or falls while the raw SCL line is low, so the block can never fake a START or STOP. A write strobe never names a register outside the map. The identifier read, soft reset to defaults, pointer wrap, out-of-range pointer loads, read-only status and cancelled bytes depend on whole bus transactions. Only the bench's scenarios can show them, by comparing each ACK and each read byte against its behavioural register model.

// File: rtl/brt_pkg.sv
package brt_pkg;

    localparam int          REG_COUNT = 15;
    localparam int          AW        = 4;
    localparam int          DW        = 8;
    localparam logic [6:0]  DEV_ADDR  = 7'b1000100;
    localparam logic [7:0]  ID_VALUE  = 8'h7D;
    localparam logic [7:0]  RESET_KEY = 8'h46;
    localparam logic [3:0]  STAT_IDX  = 4'd8;

    typedef enum logic [3:0] {
        LS_IDLE, LS_DEV, LS_DEV_ACK, LS_PTR, LS_PTR_ACK,
        LS_WR, LS_WR_ACK, LS_RD, LS_RD_ACK
    } link_state_t;

    typedef struct packed {
        logic scl_rise;
        logic scl_fall;
        logic start;
        logic stop;
        logic sda;
    } bus_ev_t;

    typedef struct packed {
        logic          en;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
    } wr_req_t;

    function automatic logic [DW-1:0] reg_default(input int unsigned idx);
        if (idx == 0)                 return ID_VALUE;
        if (idx == 6 || idx == 7)     return 8'hFF;
        if (idx == int'(STAT_IDX))    return 8'h04;
        return 8'h00;
    endfunction

    function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] p);
        return (p == AW'(REG_COUNT - 1)) ? '0 : p + 1'b1;
    endfunction

endpackage

// File: rtl/brt_sync.sv
module brt_sync
    import brt_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    logic [STAGES-1:0] scl_q, sda_q;
    logic              scl_p, sda_p;
    logic              scl_s, sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_q <= '1;
            sda_q <= '1;
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_q <= {scl_q[STAGES-2:0], scl_i};
            sda_q <= {sda_q[STAGES-2:0], sda_i};
            scl_p <= scl_q[STAGES-1];
            sda_p <= sda_q[STAGES-1];
        end
    end

    assign scl_s = scl_q[STAGES-1];
    assign sda_s = sda_q[STAGES-1];

    always_comb begin
        ev.scl_rise = !scl_p && scl_s;
        ev.scl_fall = scl_p && !scl_s;
        ev.start    = scl_p && scl_s && sda_p && !sda_s;
        ev.stop     = scl_p && scl_s && !sda_p && sda_s;
        ev.sda      = sda_s;
    end
endmodule

// File: rtl/brt_regfile.sv
module brt_regfile
    import brt_pkg::*;
#(
    parameter int ENTRIES = REG_COUNT
) (
    input  logic          clk,
    input  logic          rst,
    input  wr_req_t       wr,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    logic [ENTRIES-1:0][DW-1:0] regs;
    logic                       soft_rst;

    assign soft_rst = wr.en && (wr.addr == '0) && (wr.data == RESET_KEY);

    for (genvar g = 0; g < ENTRIES; g++) begin : g_entry
        if (g == 0 || g == int'(STAT_IDX)) begin : g_const
            assign regs[g] = reg_default(g);
        end else begin : g_store
            logic [DW-1:0] q;
            always_ff @(posedge clk) begin
                if (rst || soft_rst)
                    q <= reg_default(g);
                else if (wr.en && wr.addr == AW'(g))
                    q <= wr.data;
            end
            assign regs[g] = q;
        end
    end

    assign rd_data = (rd_addr < AW'(ENTRIES)) ? regs[rd_addr] : '0;
endmodule

// File: rtl/brt_link.sv
module brt_link
    import brt_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  bus_ev_t       ev,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] ptr,
    output logic          sda_oe,
    output wr_req_t       wr,
    output logic          stat_pulse
);
    link_state_t   state;
    logic [3:0]    bitcnt;
    logic [DW-1:0] shreg;
    logic          rw;
    logic          mack;
    logic          collecting;

    assign collecting = (state == LS_DEV) || (state == LS_PTR) || (state == LS_WR);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= LS_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            ptr        <= '0;
            rw         <= 1'b0;
            mack       <= 1'b0;
            sda_oe     <= 1'b0;
            wr         <= '0;
            stat_pulse <= 1'b0;
        end else begin
            wr.en      <= 1'b0;
            stat_pulse <= 1'b0;
            if (ev.start) begin
                state  <= LS_DEV;
                bitcnt <= '0;
                sda_oe <= 1'b0;
            end else if (ev.stop) begin
                state  <= LS_IDLE;
                sda_oe <= 1'b0;
            end else if (collecting) begin
                if (ev.scl_rise && bitcnt < 4'd8) begin
                    shreg  <= {shreg[DW-2:0], ev.sda};
                    bitcnt <= bitcnt + 1'b1;
                end else if (ev.scl_fall && bitcnt == 4'd8) begin
                    bitcnt <= '0;
                    if (state == LS_DEV) begin
                        if (shreg[7:1] == DEV_ADDR) begin
                            state  <= LS_DEV_ACK;
                            sda_oe <= 1'b1;
                            rw     <= shreg[0];
                        end else begin
                            state  <= LS_IDLE;
                        end
                    end else begin
                        state  <= (state == LS_PTR) ? LS_PTR_ACK : LS_WR_ACK;
                        sda_oe <= 1'b1;
                    end
                end
            end else begin
                case (state)
                    LS_DEV_ACK: if (ev.scl_fall) begin
                        if (rw) begin
                            shreg  <= rd_data;
                            sda_oe <= !rd_data[DW-1];
                            bitcnt <= '0;
                            state  <= LS_RD;
                        end else begin
                            sda_oe <= 1'b0;
                            state  <= LS_PTR;
                        end
                    end
                    LS_PTR_ACK: if (ev.scl_fall) begin
                        sda_oe <= 1'b0;
                        ptr    <= (shreg < DW'(REG_COUNT)) ? shreg[AW-1:0] : '0;
                        state  <= LS_WR;
                    end
                    LS_WR_ACK: if (ev.scl_fall) begin
                        sda_oe  <= 1'b0;
                        wr.en   <= 1'b1;
                        wr.addr <= ptr;
                        wr.data <= shreg;
                        ptr     <= ptr_next(ptr);
                        state   <= LS_WR;
                    end
                    LS_RD: if (ev.scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            sda_oe     <= 1'b0;
                            stat_pulse <= (ptr == STAT_IDX);
                            ptr        <= ptr_next(ptr);
                            bitcnt     <= '0;
                            state      <= LS_RD_ACK;
                        end else begin
                            shreg  <= {shreg[DW-2:0], 1'b0};
                            sda_oe <= !shreg[DW-2];
                            bitcnt <= bitcnt + 1'b1;
                        end
                    end
                    LS_RD_ACK: begin
                        if (ev.scl_rise)
                            mack <= !ev.sda;
                        else if (ev.scl_fall) begin
                            if (mack) begin
                                shreg  <= rd_data;
                                sda_oe <= !rd_data[DW-1];
                                state  <= LS_RD;
                            end else begin
                                state  <= LS_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/i2c_reg_target.sv
module i2c_reg_target
    import brt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe,
    output logic          rf_wr_stb,
    output logic [AW-1:0] rf_wr_addr,
    output logic [DW-1:0] rf_wr_data,
    output logic          stat_rd_pulse
);
    bus_ev_t       ev;
    wr_req_t       wr;
    logic [AW-1:0] ptr;
    logic [DW-1:0] rd_data;

    brt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    brt_link u_link (
        .clk        (clk),
        .rst        (rst),
        .ev         (ev),
        .rd_data    (rd_data),
        .ptr        (ptr),
        .sda_oe     (sda_oe),
        .wr         (wr),
        .stat_pulse (stat_rd_pulse)
    );

    brt_regfile #(.ENTRIES(REG_COUNT)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr      (wr),
        .rd_addr (ptr),
        .rd_data (rd_data)
    );

    assign rf_wr_stb  = wr.en;
    assign rf_wr_addr = wr.addr;
    assign rf_wr_data = wr.data;
endmodule

// File: rtl/i2c_reg_target_chk.sv
module i2c_reg_target_chk (
    input logic       clk,
    input logic       rst,
    input logic       scl_i,
    input logic       sda_oe,
    input logic       rf_wr_stb,
    input logic [3:0] rf_wr_addr,
    input logic       stat_rd_pulse
);
    // R10: write strobe lasts one cycle
    p_wr_single_r10: assert property (@(posedge clk) disable iff (rst)
        rf_wr_stb |=> !rf_wr_stb);

    // R11: status pulse lasts one cycle
    p_stat_single_r11: assert property (@(posedge clk) disable iff (rst)
        stat_rd_pulse |=> !stat_rd_pulse);

    // R2: the ACK drive starts only while SCL is low
    p_oe_rise_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_i);

    // R3: released data bits change only while SCL is low
    p_oe_fall_low_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(sda_oe) |-> !scl_i);

    // R6: a write never targets a register outside the map
    p_addr_in_map_r6: assert property (@(posedge clk) disable iff (rst)
        rf_wr_stb |-> (rf_wr_addr <= 4'd14));

    // R12: quiet in the cycle after reset
    p_quiet_reset_r12: assert property (@(posedge clk)
        $past(rst) |-> (!sda_oe && !rf_wr_stb && !stat_rd_pulse));
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
    .clk           (clk),
    .rst           (rst),
    .scl_i         (scl_i),
    .sda_oe        (sda_oe),
    .rf_wr_stb     (rf_wr_stb),
    .rf_wr_addr    (rf_wr_addr),
    .stat_rd_pulse (stat_rd_pulse)
);

// File: tb/i2c_reg_target_bench.sv
`timescale 1ns/1ps
module i2c_reg_target_bench;
    localparam int Q = 10;

    logic clk = 1'b0, rst = 1'b1, scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, rf_wr_stb, stat_rd_pulse;
    logic [3:0] rf_wr_addr;
    logic [7:0] rf_wr_data;
    wire  sda_bus = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2c_reg_target u_i2c_reg_target (
        .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_bus),
        .sda_oe(sda_oe), .rf_wr_stb(rf_wr_stb), .rf_wr_addr(rf_wr_addr),
        .rf_wr_data(rf_wr_data), .stat_rd_pulse(stat_rd_pulse)
    );

    int compared = 0, mismatched = 0, stb_cnt = 0, stat_cnt = 0;
    logic [3:0] stb_a = '0;
    logic [7:0] stb_d = '0;
    logic [7:0] mdl [15];

    always @(negedge clk) begin
        if (rf_wr_stb) begin
            stb_cnt++;
            stb_a = rf_wr_addr;
            stb_d = rf_wr_data;
        end
        if (stat_rd_pulse) stat_cnt++;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    endtask

    function automatic logic [7:0] dflt(input int i);
        if (i == 0) return 8'h7D;
        if (i == 6 || i == 7) return 8'hFF;
        if (i == 8) return 8'h04;
        return 8'h00;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 15; i++) mdl[i] = dflt(i);
    endtask

    task automatic model_write(input int a, input logic [7:0] d);
        if (a == 0 && d == 8'h46) model_reset();
        else if (a != 0 && a != 8) mdl[a] = d;
    endtask

    task automatic bus_start();
        sda_m = 1; tick(Q); scl_m = 1; tick(Q); sda_m = 0; tick(Q); scl_m = 0; tick(Q);
    endtask

    task automatic bus_stop();
        sda_m = 0; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(2*Q);
    endtask

    task automatic send(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
        end
        sda_m = 1; tick(Q); scl_m = 1; tick(Q); ack = !sda_bus; tick(Q); scl_m = 0; tick(Q);
    endtask

    task automatic recv(input logic give_ack, output logic [7:0] b);
        sda_m = 1;
        for (int i = 7; i >= 0; i--) begin
            tick(Q); scl_m = 1; tick(Q); b[i] = sda_bus; tick(Q); scl_m = 0;
        end
        tick(Q); sda_m = !give_ack; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q); sda_m = 1;
    endtask

    // sends nbits of b, the last of which must be 0, then STOPs while SCL is high
    task automatic abort_byte(input logic [7:0] b, input int nbits);
        for (int i = 7; i > 8 - nbits; i--) begin
            sda_m = b[i]; tick(Q); scl_m = 1; tick(2*Q); scl_m = 0; tick(Q);
        end
        sda_m = b[8 - nbits]; tick(Q); scl_m = 1; tick(Q); sda_m = 1; tick(2*Q);
    endtask

    task automatic write_seq(input logic [7:0] p, input logic [7:0] d[$]);
        logic a;
        int   ptr, n0;
        bus_start();
        send(8'h88, a); check("R2 address ack", a, 1);
        send(p, a);     check("R2 pointer ack", a, 1);
        ptr = (p < 15) ? int'(p) : 0;
        foreach (d[i]) begin
            n0 = stb_cnt;
            send(d[i], a);
            check("R2 data ack", a, 1);
            check("R10 strobe count", stb_cnt, n0 + 1);
            check("R10 strobe addr", stb_a, ptr);
            check("R10 strobe data", stb_d, d[i]);
            model_write(ptr, d[i]);
            ptr = (ptr == 14) ? 0 : ptr + 1;
        end
        bus_stop();
    endtask

    task automatic read_seq(input string req, input logic [7:0] p, input int n);
        logic a;
        logic [7:0] b;
        int ptr;
        bus_start();
        send(8'h88, a); check("R2 address ack", a, 1);
        send(p, a);     check("R2 pointer ack", a, 1);
        bus_start();
        send(8'h89, a); check("R3 read address ack", a, 1);
        ptr = (p < 15) ? int'(p) : 0;
        for (int i = 0; i < n; i++) begin
            recv(i < n - 1, b);
            check(req, b, mdl[ptr]);
            ptr = (ptr == 14) ? 0 : ptr + 1;
        end
        bus_stop();
    endtask

    initial begin
        tick(150000);
        mismatched++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        logic a;
        int   s0, t0;
        model_reset();
        tick(5);
        check("R12 sda_oe in reset", sda_oe, 0);
        check("R12 strobe in reset", rf_wr_stb, 0);
        rst = 0;
        tick(5);
        check("R12 sda_oe idle", sda_oe, 0);

        // R8: all defaults by one burst read covering the map, R4 identifier first
        read_seq("R8 default burst", 8'h00, 15);

        // R1: foreign address gets no ACK and is ignored
        s0 = stb_cnt;
        bus_start();
        send(8'h90, a); check("R1 foreign address nack", a, 0);
        send(8'h03, a); send(8'h5C, a);
        bus_stop();
        check("R1 no write from foreign address", stb_cnt, s0);
        read_seq("R1 reg3 untouched", 8'h03, 1);

        // R3: single write then single read
        write_seq(8'h03, '{8'hA5});
        read_seq("R3 single read", 8'h03, 1);

        // R6: burst write wrapping past 0x0E, R4: non-key write to reg 0
        write_seq(8'h0D, '{8'h11, 8'h22, 8'h12, 8'h33});
        read_seq("R6 wrap burst read", 8'h0D, 4);
        read_seq("R4 id after non-key write", 8'h00, 1);

        // R6: out-of-range pointer loads 0
        read_seq("R6 high pointer reads reg0", 8'h20, 1);

        // R9: status read-only
        write_seq(8'h08, '{8'h33});
        read_seq("R9 status unchanged", 8'h08, 1);

        // R11: status pulse only for reg 8
        s0 = stat_cnt;
        read_seq("R11 burst across status", 8'h07, 2);
        check("R11 one pulse for status", stat_cnt, s0 + 1);
        s0 = stat_cnt;
        read_seq("R11 non-status read", 8'h09, 1);
        check("R11 no pulse elsewhere", stat_cnt, s0);

        // R7: STOP mid-byte and STOP after eighth bit
        s0 = stb_cnt;
        bus_start(); send(8'h88, a); send(8'h05, a);
        abort_byte(8'hA0, 4);
        check("R7 no strobe mid-byte", stb_cnt, s0);
        bus_start(); send(8'h88, a); send(8'h05, a);
        abort_byte(8'h5A, 8);
        check("R7 no strobe before ack", stb_cnt, s0);
        check("R12 sda_oe idle after abort", sda_oe, 0);
        read_seq("R7 reg5 unchanged", 8'h05, 1);

        // R5: soft reset through the key
        write_seq(8'h01, '{8'h9A, 8'h9B, 8'h9C, 8'h9D, 8'h9E, 8'h01, 8'h02});
        read_seq("R5 before key", 8'h01, 7);
        t0 = stb_cnt;
        write_seq(8'h00, '{8'h46});
        check("R10 key write strobed", stb_cnt, t0 + 1);
        read_seq("R5 defaults after key", 8'h00, 15);

        tick(20);
        check("R12 sda_oe idle at end", sda_oe, 0);
        summary();
    end
endmodule